// File: doc/BRIEF.md
# Shift-Reconfigured Spare Block Array

This block groups four identical 4-bit arithmetic units into one repairable cluster. Three logical lanes carry the functional traffic. The fourth physical unit is held in reserve. A one-hot selection code names the physical unit that leaves functional service. The other three units then serve the lanes in ascending order, so each lane moves by at most one position towards the spare.

The unit that is out of service is never left idle. Its operands come from a dedicated test port and its result goes back out on that port. Any unit, the spare included, can therefore be exercised while the three lanes keep working. Each unit has a fault-injection mask on its result, so verification can corrupt any chosen physical unit.

The routing is purely combinational. Selection of the code belongs to an external controller.

Top module: `spare_shift_array`

## Requirements
- R1: When `cfg_sel` has exactly one bit set, at position c, physical unit c is the unit taken out of functional service (c = 3 is the spare).
- R2: Lane i is computed by physical unit i when i < c and by physical unit i+1 when i >= c, where c is the isolated unit.
- R3: The isolated unit takes its operands only from `tst_a`, `tst_b` and `tst_op`, and its result appears on `tst_y`.
- R4: A fault mask applied to the isolated unit changes `tst_y` and leaves every lane output unchanged.
- R5: If `cfg_sel` is not one-hot (zero bits or several bits set), the block behaves as if unit 0 were isolated and drives `cfg_err` high. For a one-hot code, `cfg_err` is low.
- R6: Each unit computes a 4-bit result modulo 16 from the 2-bit op code: 0 = a+b, 1 = a-b, 2 = a AND b, 3 = a XOR b.
- R7: A change of `cfg_sel`, operands or masks appears on `lane_y`, `tst_y` and `cfg_err` in the same cycle, with no register on the way.
- R8: The result of physical unit u is XORed with bits [4u+3:4u] of `flt_mask` before it is routed to a lane or to the test port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_sel | input | 4 | One-hot code; bit u isolates physical unit u |
| lane_a | input | 12 | Operand A per lane; lane i in bits [4i+3:4i] |
| lane_b | input | 12 | Operand B per lane; lane i in bits [4i+3:4i] |
| lane_op | input | 6 | Op code per lane; lane i in bits [2i+1:2i] |
| tst_a | input | 4 | Operand A for the isolated unit |
| tst_b | input | 4 | Operand B for the isolated unit |
| tst_op | input | 2 | Op code for the isolated unit |
| flt_mask | input | 16 | Fault mask; unit u in bits [4u+3:4u] |
| lane_y | output | 12 | Lane results; lane i in bits [4i+3:4i] |
| tst_y | output | 4 | Result of the isolated unit |
| cfg_err | output | 1 | High when `cfg_sel` is not one-hot |

## Verification
The lane outputs and the test port are served in the same cycle by different physical units. A fault placed on one unit must therefore reach exactly one of them. The bench sweeps every one of the sixteen `cfg_sel` codes, every op code and a range of operands. In each vector it injects a nonzero mask into a single physical unit, or into none. It then predicts which lane, or the test port, must show the corrupted value. Because every lane and the test port carry distinct operands, a result steered to the wrong place is reported as a miscompare on that output.

// File: rtl/spare_shift_array.sv
module spare_shift_array #(
  parameter int W     = 4,
  parameter int LANES = 3
) (
  input  logic [LANES:0]           cfg_sel,
  input  logic [LANES*W-1:0]       lane_a,
  input  logic [LANES*W-1:0]       lane_b,
  input  logic [LANES*2-1:0]       lane_op,
  input  logic [W-1:0]             tst_a,
  input  logic [W-1:0]             tst_b,
  input  logic [1:0]               tst_op,
  input  logic [(LANES+1)*W-1:0]   flt_mask,
  output logic [LANES*W-1:0]       lane_y,
  output logic [W-1:0]             tst_y,
  output logic                     cfg_err
);
  localparam int UNITS = LANES + 1;
  localparam int IW    = $clog2(UNITS);

  function automatic logic [W-1:0] alu(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [1:0] op);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  logic [IW-1:0] iso;
  logic          one_hot;

  always_comb begin
    int ones;
    ones = 0;
    iso  = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (cfg_sel[u]) begin
        ones = ones + 1;
        iso  = IW'(u);
      end
    end
    one_hot = (ones == 1);
    if (!one_hot) iso = '0;
  end

  assign cfg_err = !one_hot;

  logic [W-1:0] uy [UNITS];

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [W-1:0] ua, ub;
    logic [1:0]   uop;
    logic         is_iso, from_prev;
    assign is_iso    = (iso == IW'(u));
    assign from_prev = (iso < IW'(u));
    if (u == 0) begin : g_first
      always_comb begin
        ua  = is_iso ? tst_a  : lane_a[W-1:0];
        ub  = is_iso ? tst_b  : lane_b[W-1:0];
        uop = is_iso ? tst_op : lane_op[1:0];
      end
    end else if (u == UNITS-1) begin : g_last
      always_comb begin
        ua  = is_iso ? tst_a  : lane_a[(u-1)*W +: W];
        ub  = is_iso ? tst_b  : lane_b[(u-1)*W +: W];
        uop = is_iso ? tst_op : lane_op[(u-1)*2 +: 2];
      end
    end else begin : g_mid
      always_comb begin
        if (is_iso) begin
          ua = tst_a; ub = tst_b; uop = tst_op;
        end else if (from_prev) begin
          ua = lane_a[(u-1)*W +: W]; ub = lane_b[(u-1)*W +: W]; uop = lane_op[(u-1)*2 +: 2];
        end else begin
          ua = lane_a[u*W +: W]; ub = lane_b[u*W +: W]; uop = lane_op[u*2 +: 2];
        end
      end
    end
    assign uy[u] = alu(ua, ub, uop) ^ flt_mask[u*W +: W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_y[i*W +: W] = (IW'(i) < iso) ? uy[i] : uy[i+1];
  end

  assign tst_y = uy[iso];
endmodule

// File: rtl/spare_shift_array_chk.sv
module spare_shift_array_chk #(
  parameter int W     = 4,
  parameter int LANES = 3
) (
  input logic [LANES:0]           cfg_sel,
  input logic [LANES*W-1:0]       lane_a,
  input logic [LANES*W-1:0]       lane_b,
  input logic [LANES*2-1:0]       lane_op,
  input logic [W-1:0]             tst_a,
  input logic [W-1:0]             tst_b,
  input logic [1:0]               tst_op,
  input logic [(LANES+1)*W-1:0]   flt_mask,
  input logic [LANES*W-1:0]       lane_y,
  input logic [W-1:0]             tst_y,
  input logic                     cfg_err
);
  function automatic logic [W-1:0] ref_op(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [1:0] op);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  always_comb begin
    logic [(LANES+1)*W-1:0] other;
    int c;
    c = 0;
    for (int u = 0; u <= LANES; u++) if (cfg_sel[u]) c = u;
    if ($countones(cfg_sel) != 1) c = 0;
    other = flt_mask;
    other[c*W +: W] = '0;

    // R5
    bad_code_flag_chk: assert (($countones(cfg_sel) == 1) == !cfg_err)
      else $error("cfg_err does not match code");

    // R3
    if (flt_mask == '0)
      test_path_chk: assert (tst_y == ref_op(tst_a, tst_b, tst_op))
        else $error("test port result wrong");

    for (int i = 0; i < LANES; i++) begin
      // R2
      if (flt_mask == '0)
        lane_clean_chk: assert (lane_y[i*W +: W] ==
                                ref_op(lane_a[i*W +: W], lane_b[i*W +: W], lane_op[i*2 +: 2]))
          else $error("lane %0d result wrong", i);
      // R4
      if (other == '0)
        iso_fault_hidden_chk: assert (lane_y[i*W +: W] ==
                                      ref_op(lane_a[i*W +: W], lane_b[i*W +: W], lane_op[i*2 +: 2]))
          else $error("fault on isolated unit leaked to lane %0d", i);
    end
  end
endmodule

bind spare_shift_array spare_shift_array_chk #(.W(W), .LANES(LANES)) chk_i (
  .cfg_sel(cfg_sel), .lane_a(lane_a), .lane_b(lane_b), .lane_op(lane_op),
  .tst_a(tst_a), .tst_b(tst_b), .tst_op(tst_op), .flt_mask(flt_mask),
  .lane_y(lane_y), .tst_y(tst_y), .cfg_err(cfg_err)
);

// File: tb/spare_shift_array_tb.sv
module spare_shift_array_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  cfg_sel;
  logic [11:0] lane_a, lane_b;
  logic [5:0]  lane_op;
  logic [3:0]  tst_a, tst_b;
  logic [1:0]  tst_op;
  logic [15:0] flt_mask;
  logic [11:0] lane_y;
  logic [3:0]  tst_y;
  logic        cfg_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spare_shift_array dut_i (
    .cfg_sel(cfg_sel), .lane_a(lane_a), .lane_b(lane_b), .lane_op(lane_op),
    .tst_a(tst_a), .tst_b(tst_b), .tst_op(tst_op), .flt_mask(flt_mask),
    .lane_y(lane_y), .tst_y(tst_y), .cfg_err(cfg_err)
  );

  function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b, input logic [1:0] op);
    case (op)
      2'd0:    return 4'((int'(a) + int'(b)) % 16);
      2'd1:    return 4'((int'(a) - int'(b) + 16) % 16);
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    cfg_sel = 4'b0001; lane_a = '0; lane_b = '0; lane_op = '0;
    tst_a = '0; tst_b = '0; tst_op = '0; flt_mask = '0;
    @(negedge clk);
    vectors++;
    check("R1 R6 idle lane0", lane_y[3:0], 4'h0);
    check("R2 idle lane2", lane_y[11:8], 4'h0);
    check("R3 idle test port", tst_y, 4'h0);
    check("R5 idle cfg_err", {3'b0, cfg_err}, 4'h0);

    for (int cfg = 0; cfg < 16; cfg++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 16; a++)
          for (int f = 0; f < 5; f++) begin
            int ones, c, b;
            logic [3:0] pat, la, lb, exp;
            logic [1:0] lop;
            @(posedge clk);
            b = (a * 7 + op * 3 + cfg) % 16;
            pat = 4'(a | 1);
            cfg_sel = 4'(cfg);
            for (int i = 0; i < 3; i++) begin
              lane_a[i*4 +: 4]  = 4'((a + 3*i) % 16);
              lane_b[i*4 +: 4]  = 4'(b ^ i);
              lane_op[i*2 +: 2] = 2'((op + i) % 4);
            end
            tst_a = 4'(a ^ 5); tst_b = 4'((b + 7) % 16); tst_op = 2'(op ^ 1);
            flt_mask = '0;
            if (f < 4) flt_mask[f*4 +: 4] = pat;
            @(negedge clk);
            vectors++;
            ones = 0; c = 0;
            for (int u = 0; u < 4; u++) if (((cfg >> u) & 1) == 1) begin ones++; c = u; end
            if (ones != 1) c = 0;
            // R5: non-one-hot code falls back to unit 0 and flags
            check("R5 cfg_err", {3'b0, cfg_err}, (ones != 1) ? 4'h1 : 4'h0);
            for (int i = 0; i < 3; i++) begin
              int unit;
              unit = (i < c) ? i : i + 1;
              la = 4'((a + 3*i) % 16); lb = 4'(b ^ i); lop = 2'((op + i) % 4);
              exp = model(la, lb, lop) ^ ((unit == f) ? pat : 4'h0);
              // R1 R2 R4 R6 R7 R8: lane served by the shifted unit, same cycle
              check($sformatf("R2 R4 R8 lane%0d cfg=%h", i, cfg), lane_y[i*4 +: 4], exp);
            end
            exp = model(4'(a ^ 5), 4'((b + 7) % 16), 2'(op ^ 1)) ^ ((c == f) ? pat : 4'h0);
            check($sformatf("R1 R3 R7 test port cfg=%h", cfg), tst_y, exp);
          end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule